// File: doc/BRIEF.md
# Parallel Double-Edge I/Q Capture

This block receives sample data from a device that drives a bus of parallel I lines and a bus of parallel Q lines, and turns it into aligned I/Q words in the rising-edge domain of the interface clock. The device can present a full complex sample on one clock edge. It can also spread one complex sample over both edges of a cycle on the I lines alone, in I-first or Q-first order, or send two real values per cycle on the I lines.

A configurable extractor runs on every captured line group. It can reverse the line order, take a word of 4 to 16 bits from either end of the bus and clear the lines above the word. A polarity control moves the start of a sample from the rising to the falling edge. The block re-registers everything into the rising-edge domain. It then emits one output beat per clock, with a valid strobe and a flag that marks a real-valued beat carrying two samples.

Top module: `iqDdrCapture`

## Requirements
- R1: With `cfgMode` = 0 (plain), `outI` is the word from the I lines and `outQ` the word from the Q lines, both captured on the sample's start edge.
- R2: With `cfgMode` = 1 (I-first interleave), `outI` is the word the I lines carried on the start edge, and `outQ` is the word they carried on the opposite edge half a cycle later.
- R3: With `cfgMode` = 2 (Q-first interleave), `outQ` is the word the I lines carried on the start edge, and `outI` is the word they carried on the following opposite edge.
- R4: With `cfgMode` = 3 (real), `outI` holds the start-edge real sample and `outQ` holds the next opposite-edge real sample, and `outDual` is 1. In every other mode `outDual` is 0.
- R5: With `cfgClkInv` = 0 a sample starts on the rising edge. With `cfgClkInv` = 1 it starts on the falling edge, and its second half comes from the rising edge that follows.
- R6: The effective word width is `cfgWordSize` clamped to the range 4 to 16, and every output bit at or above that width is 0.
- R7: With `cfgAlignMsb` = 0 the word is bus bits [W-1:0]. With `cfgAlignMsb` = 1 it is bus bits [15:16-W]. In both cases the word is returned right-justified.
- R8: With `cfgLine0Msb` = 0, bus bit k is line k. With `cfgLine0Msb` = 1, bus bit k is line 15-k, so line 0 carries the most significant bus bit.
- R9: Reset clears the outputs. After reset is released, `outValid` stays low through the first two rising edges, rises after the third, and then stays high every cycle while mode and polarity hold.
- R10: When `cfgMode` or `cfgClkInv` changes, `outValid` is low after the rising edge that first sees the change and after the next two, and high again after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; data sampled on both edges |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | 0 plain, 1 I-first interleave, 2 Q-first interleave, 3 real |
| cfgClkInv | input | 1 | 1 starts each sample on the falling edge |
| cfgWordSize | input | 5 | Word width in bits, clamped to 4..16 |
| cfgAlignMsb | input | 1 | 1 takes the word from the top of the bus |
| cfgLine0Msb | input | 1 | 1 reverses the line-to-bit order |
| iLines | input | 16 | I data lines |
| qLines | input | 16 | Q data lines |
| outValid | output | 1 | Output beat valid |
| outI | output | 16 | I word, or first real sample |
| outQ | output | 16 | Q word, or second real sample |
| outDual | output | 1 | Beat carries two real samples |

## Verification
If the edge registers or the pairing select are wrong, the halves of a sample get swapped or paired across sample boundaries. A stream that counts per half-cycle shows this one cycle after capture as a wrong parity of `outI`, or as `outQ` not equal to `outI + 1`. If the warm-up counter is wrong, `outValid` moves one or more edges early or late after reset or a mode change, which shows within three cycles. Extractor faults show as wrong constant words after a single beat.

// File: rtl/iqcap_pkg.sv
package iqcap_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_IQ    = 2'd1,
    MODE_QI    = 2'd2,
    MODE_REAL  = 2'd3
  } capMode_e;

  typedef struct packed {
    logic     emit;
    logic     useFall;
    capMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/iqcap_lane.sv
module iqcap_lane #(
  parameter int LINES = 16,
  parameter int SIZEW = 5
) (
  input  logic [LINES-1:0] lines,
  input  logic [SIZEW-1:0] width,
  input  logic             alignMsb,
  input  logic             line0Msb,
  output logic [LINES-1:0] word
);
  logic [LINES-1:0] reversed;
  logic [LINES-1:0] bus;
  logic [LINES-1:0] mask;
  logic [SIZEW-1:0] shamt;

  for (genvar b = 0; b < LINES; b++) begin : g_rev
    assign reversed[b] = lines[LINES-1-b];
  end

  always_comb begin
    bus   = line0Msb ? reversed : lines;
    shamt = SIZEW'(LINES) - width;
    mask  = {LINES{1'b1}} >> shamt;
    word  = (alignMsb ? (bus >> shamt) : bus) & mask;
  end
endmodule

// File: rtl/iqcap_ctrl.sv
module iqcap_ctrl
  import iqcap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cfgMode,
  input  logic        cfgClkInv,
  output ctrlStrobe_t strobe
);
  logic [2:0] cfgPrev;
  logic [1:0] warm;
  logic       changed;

  always_ff @(posedge clk) cfgPrev <= {cfgClkInv, cfgMode};

  assign changed = ({cfgClkInv, cfgMode} != cfgPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= 2'd0;
    else if (changed)       warm <= 2'd0;
    else if (warm != 2'd2)  warm <= warm + 2'd1;
  end

  always_comb begin
    strobe.emit    = (warm == 2'd2) && !changed;
    strobe.useFall = cfgClkInv;
    strobe.mode    = capMode_e'(cfgMode);
  end
endmodule

// File: rtl/iqcap_datapath.sv
module iqcap_datapath
  import iqcap_pkg::*;
#(
  parameter int LINES = 16,
  parameter int SIZEW = 5,
  parameter int MINW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [SIZEW-1:0] wordSize,
  input  logic             alignMsb,
  input  logic             line0Msb,
  input  logic [LINES-1:0] iLines,
  input  logic [LINES-1:0] qLines,
  output logic             outValid,
  output logic [LINES-1:0] outI,
  output logic [LINES-1:0] outQ,
  output logic             outDual
);
  localparam int NLANE = 3;
  localparam logic [SIZEW-1:0] LO_W = SIZEW'(MINW);
  localparam logic [SIZEW-1:0] HI_W = SIZEW'(LINES);

  logic [LINES-1:0] riseI, riseQ, fallI, fallQ, fallISync, fallQSync;
  logic [LINES-1:0] laneIn  [NLANE];
  logic [LINES-1:0] laneOut [NLANE];
  logic [SIZEW-1:0] effW;
  logic [LINES-1:0] nextI, nextQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseI <= '0; riseQ <= '0; fallISync <= '0; fallQSync <= '0;
    end else begin
      riseI <= iLines; riseQ <= qLines;
      fallISync <= fallI; fallQSync <= fallQ;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      fallI <= '0; fallQ <= '0;
    end else begin
      fallI <= iLines; fallQ <= qLines;
    end
  end

  always_comb begin
    if (wordSize < LO_W)      effW = LO_W;
    else if (wordSize > HI_W) effW = HI_W;
    else                      effW = wordSize;
    // lane 0: start-edge I lines, lane 1: start-edge Q lines, lane 2: I lines on the following edge
    if (strobe.useFall) begin
      laneIn[0] = fallISync; laneIn[1] = fallQSync; laneIn[2] = riseI;
    end else begin
      laneIn[0] = riseI;     laneIn[1] = riseQ;     laneIn[2] = fallI;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    iqcap_lane #(.LINES(LINES), .SIZEW(SIZEW)) u_lane (
      .lines(laneIn[g]), .width(effW), .alignMsb(alignMsb),
      .line0Msb(line0Msb), .word(laneOut[g])
    );
  end

  always_comb begin
    unique case (strobe.mode)
      MODE_PLAIN: begin nextI = laneOut[0]; nextQ = laneOut[1]; end
      MODE_QI:    begin nextI = laneOut[2]; nextQ = laneOut[0]; end
      default:    begin nextI = laneOut[0]; nextQ = laneOut[2]; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0; outDual <= 1'b0; outI <= '0; outQ <= '0;
    end else begin
      outValid <= strobe.emit;
      outDual  <= strobe.emit && (strobe.mode == MODE_REAL);
      outI     <= nextI;
      outQ     <= nextQ;
    end
  end
endmodule

// File: rtl/iqDdrCapture.sv
module iqDdrCapture
  import iqcap_pkg::*;
#(
  parameter int LINES = 16,
  parameter int MINW  = 4,
  localparam int SIZEW = $clog2(LINES) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic             cfgClkInv,
  input  logic [SIZEW-1:0] cfgWordSize,
  input  logic             cfgAlignMsb,
  input  logic             cfgLine0Msb,
  input  logic [LINES-1:0] iLines,
  input  logic [LINES-1:0] qLines,
  output logic             outValid,
  output logic [LINES-1:0] outI,
  output logic [LINES-1:0] outQ,
  output logic             outDual
);
  ctrlStrobe_t strobe;

  iqcap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgClkInv(cfgClkInv), .strobe(strobe)
  );

  iqcap_datapath #(.LINES(LINES), .SIZEW(SIZEW), .MINW(MINW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordSize(cfgWordSize),
    .alignMsb(cfgAlignMsb), .line0Msb(cfgLine0Msb), .iLines(iLines), .qLines(qLines),
    .outValid(outValid), .outI(outI), .outQ(outQ), .outDual(outDual)
  );
endmodule

// File: rtl/iqcap_checker.sv
module iqcap_checker #(
  parameter int LINES = 16,
  parameter int SIZEW = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       cfgMode,
  input logic             cfgClkInv,
  input logic [SIZEW-1:0] cfgWordSize,
  input logic             outValid,
  input logic [LINES-1:0] outI,
  input logic [LINES-1:0] outQ,
  input logic             outDual
);
  function automatic logic [SIZEW-1:0] limitW(input logic [SIZEW-1:0] w);
    if (w < SIZEW'(4))          return SIZEW'(4);
    else if (w > SIZEW'(LINES)) return SIZEW'(LINES);
    else                        return w;
  endfunction

  p_dual_real_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outDual == ($past(cfgMode) == 2'd3)));

  p_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (((outI >> limitW($past(cfgWordSize))) == '0) &&
                  ((outQ >> limitW($past(cfgWordSize))) == '0)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $stable(cfgMode) && $stable(cfgClkInv)) |=> outValid);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgMode != $past(cfgMode)) || (cfgClkInv != $past(cfgClkInv))) |=> !outValid);
endmodule

bind iqDdrCapture iqcap_checker #(.LINES(LINES), .SIZEW(SIZEW)) u_chk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgClkInv(cfgClkInv),
  .cfgWordSize(cfgWordSize), .outValid(outValid), .outI(outI), .outQ(outQ),
  .outDual(outDual)
);

// File: tb/sim_iqDdrCapture.sv
module sim_iqDdrCapture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic        cfgClkInv = 1'b0;
  logic [4:0]  cfgWordSize = 5'd16;
  logic        cfgAlignMsb = 1'b0;
  logic        cfgLine0Msb = 1'b0;
  logic [15:0] iLines = '0, qLines = '0;
  logic        outValid, outDual;
  logic [15:0] outI, outQ;

  logic [15:0] riseI = 16'hABCD, riseQ = 16'h1234, fallI = 16'h5E71, fallQ = 16'h9F08;
  logic        streaming = 1'b0;
  logic [15:0] cnt = '0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  iqDdrCapture u0 (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgClkInv(cfgClkInv),
    .cfgWordSize(cfgWordSize), .cfgAlignMsb(cfgAlignMsb), .cfgLine0Msb(cfgLine0Msb),
    .iLines(iLines), .qLines(qLines), .outValid(outValid), .outI(outI),
    .outQ(outQ), .outDual(outDual)
  );

  always #4 clk = ~clk;

  // data driver: rising-edge values set after a falling edge, falling-edge values after a rising edge
  initial begin
    forever begin
      @(negedge clk); #2;
      if (streaming) begin iLines = cnt; qLines = ~cnt; end
      else begin iLines = riseI; qLines = riseQ; end
      cnt = cnt + 16'd1;
      @(posedge clk); #2;
      if (streaming) begin iLines = cnt; qLines = ~cnt; end
      else begin iLines = fallI; qLines = fallQ; end
      cnt = cnt + 16'd1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic setCfg(input logic [1:0] m, input logic inv, input logic [4:0] w,
                        input logic am, input logic l0);
    @(negedge clk); #1;
    cfgMode = m; cfgClkInv = inv; cfgWordSize = w; cfgAlignMsb = am; cfgLine0Msb = l0;
    settle();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset valid", {15'd0, outValid}, 16'd0);
    chk("R9 reset outI", outI, 16'd0);
    chk("R9 reset dual", {15'd0, outDual}, 16'd0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R9 valid after edge 1", {15'd0, outValid}, 16'd0);
    @(negedge clk); #1;
    chk("R9 valid after edge 2", {15'd0, outValid}, 16'd0);
    @(negedge clk); #1;
    chk("R9 valid after edge 3", {15'd0, outValid}, 16'd1);
  endtask

  task automatic t_plain();
    setCfg(2'd0, 1'b0, 5'd16, 1'b0, 1'b0);
    chk("R1 plain I", outI, 16'hABCD);
    chk("R1 plain Q", outQ, 16'h1234);
    chk("R4 dual low in plain", {15'd0, outDual}, 16'd0);
    chk("R9 valid steady", {15'd0, outValid}, 16'd1);
    setCfg(2'd0, 1'b1, 5'd16, 1'b0, 1'b0);
    chk("R5 plain inv I", outI, 16'h5E71);
    chk("R5 plain inv Q", outQ, 16'h9F08);
  endtask

  task automatic t_interleave();
    setCfg(2'd1, 1'b0, 5'd16, 1'b0, 1'b0);
    chk("R2 iq I", outI, 16'hABCD);
    chk("R2 iq Q", outQ, 16'h5E71);
    setCfg(2'd2, 1'b0, 5'd16, 1'b0, 1'b0);
    chk("R3 qi I", outI, 16'h5E71);
    chk("R3 qi Q", outQ, 16'hABCD);
    setCfg(2'd2, 1'b1, 5'd16, 1'b0, 1'b0);
    chk("R3 R5 qi inv I", outI, 16'hABCD);
    chk("R3 R5 qi inv Q", outQ, 16'h5E71);
  endtask

  task automatic t_real();
    setCfg(2'd3, 1'b0, 5'd16, 1'b0, 1'b0);
    chk("R4 real first", outI, 16'hABCD);
    chk("R4 real second", outQ, 16'h5E71);
    chk("R4 real dual", {15'd0, outDual}, 16'd1);
  endtask

  task automatic t_words();
    setCfg(2'd0, 1'b0, 5'd8, 1'b0, 1'b0);
    chk("R7 lsb align I", outI, 16'h00CD);
    chk("R7 lsb align Q", outQ, 16'h0034);
    setCfg(2'd0, 1'b0, 5'd8, 1'b1, 1'b0);
    chk("R7 msb align I", outI, 16'h00AB);
    chk("R7 msb align Q", outQ, 16'h0012);
    setCfg(2'd0, 1'b0, 5'd8, 1'b0, 1'b1);
    chk("R8 reversed lsb I", outI, 16'h00D5);
    chk("R8 reversed lsb Q", outQ, 16'h0048);
    setCfg(2'd0, 1'b0, 5'd8, 1'b1, 1'b1);
    chk("R8 reversed msb I", outI, 16'h00B3);
    chk("R8 reversed msb Q", outQ, 16'h002C);
    setCfg(2'd0, 1'b0, 5'd16, 1'b0, 1'b1);
    chk("R8 reversed full", outI, 16'hB3D5);
    setCfg(2'd0, 1'b0, 5'd4, 1'b1, 1'b0);
    chk("R6 width 4 msb", outI, 16'h000A);
    setCfg(2'd0, 1'b0, 5'd2, 1'b0, 1'b0);
    chk("R6 clamp low", outI, 16'h000D);
    setCfg(2'd0, 1'b0, 5'd0, 1'b1, 1'b0);
    chk("R6 clamp low msb", outI, 16'h000A);
    setCfg(2'd0, 1'b0, 5'd31, 1'b1, 1'b0);
    chk("R6 clamp high", outI, 16'hABCD);
  endtask

  task automatic t_stream(input logic inv);
    setCfg(2'd1, inv, 5'd16, 1'b0, 1'b0);
    streaming = 1'b1;
    settle();
    for (int k = 0; k < 4; k++) begin
      chk(inv ? "R5 R2 stream pair inv" : "R2 stream pair", outQ, outI + 16'd1);
      chk(inv ? "R5 stream parity inv" : "R5 stream parity", {15'd0, outI[0]}, {15'd0, inv});
      @(negedge clk); #1;
    end
    streaming = 1'b0;
  endtask

  task automatic t_flush();
    setCfg(2'd0, 1'b0, 5'd16, 1'b0, 1'b0);
    chk("R10 valid before change", {15'd0, outValid}, 16'd1);
    cfgMode = 2'd1;
    @(negedge clk); #1;
    chk("R10 low after edge 1", {15'd0, outValid}, 16'd0);
    @(negedge clk); #1;
    chk("R10 low after edge 2", {15'd0, outValid}, 16'd0);
    @(negedge clk); #1;
    chk("R10 low after edge 3", {15'd0, outValid}, 16'd0);
    @(negedge clk); #1;
    chk("R10 high after edge 4", {15'd0, outValid}, 16'd1);
    chk("R10 R2 data after change", outQ, 16'h5E71);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_interleave();
    t_real();
    t_words();
    t_stream(1'b0);
    t_stream(1'b1);
    t_flush();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule